// File: doc/BRIEF.md
# Flash Toggle-Bit Poll Controller

This block sits on the host side of an external parallel flash and decides when an embedded program or erase operation has finished. After a one-cycle `start` pulse it reads the flash status byte over and over, keeps the selected toggle bit from one read, and compares it with the same bit in the next read. A bit that holds still means the operation is over and it succeeded. A bit that keeps changing means the operation is still running, unless the timeout flag (bit 5) is also set.

When the timeout flag is seen with a changing toggle bit, the controller does not declare failure right away. The toggle bit may have stopped in the same moment the flag rose, so the controller takes one more read and compares again. Failure is declared only when the bit is still changing on that re-check. On failure the controller sends one reset-command write, which returns the flash to array-read mode. After a successful finish, the next read the host makes returns array data.

Requests to the flash bus use valid/ready. A request stays on the bus, unchanged, until the bus accepts it. Read data comes back on a valid/ready response channel, and the controller raises `rsp_ready` only while it waits for read data, so a response cannot arrive early. `start`, `busy`, `done` and `error` are plain control and status pins.

Top module: `flash_toggle_poller`

## Requirements
- R1: After reset, `busy`, `done`, `error`, `req_valid` and `rsp_ready` are all low.
- R2: A `start` pulse while idle begins polling with a read request. A `start` pulse while `busy` is high has no effect on the number of reads issued or on the outcome.
- R3: Once `req_valid` is high, it stays high with `req_write` and `req_data` unchanged until a cycle where `req_ready` is high. A read request has `req_write` = 0.
- R4: `rsp_ready` is high only while a read response is awaited. Read data is taken in a cycle where `rsp_valid` and `rsp_ready` are both high.
- R5: Polling always starts with two reads. The toggle bit of the first read is stored and compared with the toggle bit of the second. If they are equal, the controller reports success: `done` is high and `error` is low in the cycle after that response handshake, and no write is issued.
- R6: If the toggle bit changed and bit 5 of the latest read is 0, the controller issues another read and compares it with the previous read. It repeats this until it reaches a terminating result.
- R7: If the toggle bit changed and bit 5 of the latest read is 1, exactly one more read is taken. If its toggle bit equals that of the read before it, the result is success.
- R8: If the toggle bit still changed on that re-check, the controller issues exactly one write with `req_write` = 1 and `req_data` = 0xF0. In the cycle after that write is accepted, `done` and `error` are both high. `error` is never high without `done`.
- R9: `busy` is high from the cycle after an accepted `start` until the final handshake. `done` is high for exactly one cycle, and `busy` is low in that cycle.
- R10: With the default setting, the toggle bit is bit 6. Bits other than bit 6 and bit 5 do not affect the number of reads or the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that begins polling |
| busy | output | 1 | Polling in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | High with `done` when the operation failed |
| req_valid | output | 1 | Bus request valid |
| req_ready | input | 1 | Bus accepts the request |
| req_write | output | 1 | 1 = write, 0 = read |
| req_data | output | 8 | Write data (reset command) |
| rsp_valid | input | 1 | Read data valid |
| rsp_ready | output | 1 | Controller waiting for read data |
| rsp_data | input | 8 | Status byte read from the flash |

## Verification
Each polling case is built from the number of reads in which the toggle bit keeps flipping and the read index at which bit 5 rises. These two numbers steer the controller down the direct-success path, the keep-polling path, the re-check success path or the failure path, so a wrong count of reads or a wrong outcome shows exactly which decision went wrong. Every other status bit, bit 2 included, carries random noise, which separates a correct choice of toggle bit from a wrong one. Random stalls on request acceptance and response return test that requests are held. A second `start` pulse in the middle of a run shows whether a restart leaks into the read count.

// File: rtl/fpoll_pkg.sv
package fpoll_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RDREQ,
    ST_RDWAIT,
    ST_WRREQ,
    ST_DONE
  } poll_state_t;

  typedef enum logic [1:0] {
    PH_FIRST,
    PH_TRACK,
    PH_RECHECK
  } poll_phase_t;
endpackage

// File: rtl/fpoll_bitcmp.sv
module fpoll_bitcmp #(
  parameter int DW          = 8,
  parameter int TOGGLE_POS  = 6,
  parameter int TIMEOUT_POS = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] sample,
  output logic          changed,
  output logic          timeout
);
  logic ref_q;
  logic cur_bit;

  generate
    if (TOGGLE_POS >= 0 && TOGGLE_POS < DW) begin : g_sel
      assign cur_bit = sample[TOGGLE_POS];
    end else begin : g_sel_dflt
      assign cur_bit = sample[DW-2];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) ref_q <= 1'b0;
    else if (load) ref_q <= cur_bit;
  end

  assign changed = cur_bit != ref_q;
  assign timeout = sample[TIMEOUT_POS];

  // R5: after a load the stored bit is the bit that was sampled
  a_r5_ref_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> ref_q == $past(cur_bit));
endmodule

// File: rtl/fpoll_reqgen.sv
module fpoll_reqgen
  import fpoll_pkg::*;
#(
  parameter int          DW      = 8,
  parameter logic [7:0]  RST_CMD = 8'hF0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  poll_state_t   state,
  input  logic          req_ready,
  output logic          req_valid,
  output logic          req_write,
  output logic [DW-1:0] req_data,
  output logic          rsp_ready
);
  always_comb begin
    req_valid = (state == ST_RDREQ) || (state == ST_WRREQ);
    req_write = (state == ST_WRREQ);
    req_data  = (state == ST_WRREQ) ? DW'(RST_CMD) : '0;
    rsp_ready = (state == ST_RDWAIT);
  end

  // R3: a pending request is held unchanged until accepted
  a_r3_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_write) && $stable(req_data));

  // R8: every write carries the reset command
  a_r8_write_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write |-> req_data == DW'(RST_CMD));

  // R4: never awaiting data while requesting
  a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_ready && req_valid));
endmodule

// File: rtl/fpoll_seq.sv
module fpoll_seq
  import fpoll_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        req_ready,
  input  logic        rsp_valid,
  input  logic        rsp_ready,
  input  logic        changed,
  input  logic        timeout,
  output poll_state_t state,
  output logic        load_ref,
  output logic        busy,
  output logic        done,
  output logic        error
);
  poll_state_t state_q, state_d;
  poll_phase_t phase_q, phase_d;
  logic        fail_q, fail_d;
  logic        rsp_fire;

  assign rsp_fire = rsp_valid && rsp_ready;
  assign load_ref = rsp_fire && ((phase_q == PH_FIRST) ||
                                 (phase_q == PH_TRACK && changed));

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    fail_d  = fail_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_RDREQ;
          phase_d = PH_FIRST;
          fail_d  = 1'b0;
        end
      end
      ST_RDREQ: begin
        if (req_ready) state_d = ST_RDWAIT;
      end
      ST_RDWAIT: begin
        if (rsp_fire) begin
          unique case (phase_q)
            PH_FIRST: begin
              phase_d = PH_TRACK;
              state_d = ST_RDREQ;
            end
            PH_TRACK: begin
              if (!changed) state_d = ST_DONE;
              else begin
                state_d = ST_RDREQ;
                if (timeout) phase_d = PH_RECHECK;
              end
            end
            default: begin
              if (!changed) state_d = ST_DONE;
              else state_d = ST_WRREQ;
            end
          endcase
        end
      end
      ST_WRREQ: begin
        if (req_ready) begin
          state_d = ST_DONE;
          fail_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= PH_FIRST;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      fail_q  <= fail_d;
    end
  end

  assign state = state_q;
  assign done  = (state_q == ST_DONE);
  assign error = done && fail_q;
  assign busy  = (state_q != ST_IDLE) && (state_q != ST_DONE);

  // R9: completion is a single-cycle pulse with busy low
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R8: error only accompanies done
  a_r8_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> done);
  // R5: unchanged toggle during tracking ends in success
  a_r5_success: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fire && phase_q == PH_TRACK && !changed |=> done && !error);
  // R6: changed toggle with timeout clear keeps polling
  a_r6_keep_polling: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fire && phase_q == PH_TRACK && changed && !timeout |=> busy && !done);
  // R7: re-check that sees a steady bit succeeds
  a_r7_recheck_ok: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fire && phase_q == PH_RECHECK && !changed |=> done && !error);
endmodule

// File: rtl/flash_toggle_poller.sv
module flash_toggle_poller
  import fpoll_pkg::*;
#(
  parameter int         DW          = 8,
  parameter int         TOGGLE_POS  = 6,
  parameter int         TIMEOUT_POS = 5,
  parameter logic [7:0] RST_CMD     = 8'hF0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic          error,
  output logic          req_valid,
  input  logic          req_ready,
  output logic          req_write,
  output logic [DW-1:0] req_data,
  input  logic          rsp_valid,
  output logic          rsp_ready,
  input  logic [DW-1:0] rsp_data
);
  poll_state_t state;
  logic        load_ref;
  logic        changed;
  logic        timeout;

  fpoll_bitcmp #(
    .DW(DW), .TOGGLE_POS(TOGGLE_POS), .TIMEOUT_POS(TIMEOUT_POS)
  ) u_cmp (
    .clk(clk), .rst_n(rst_n), .load(load_ref), .sample(rsp_data),
    .changed(changed), .timeout(timeout)
  );

  fpoll_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .changed(changed),
    .timeout(timeout), .state(state), .load_ref(load_ref),
    .busy(busy), .done(done), .error(error)
  );

  fpoll_reqgen #(.DW(DW), .RST_CMD(RST_CMD)) u_req (
    .clk(clk), .rst_n(rst_n), .state(state), .req_ready(req_ready),
    .req_valid(req_valid), .req_write(req_write), .req_data(req_data),
    .rsp_ready(rsp_ready)
  );

  // R2: an idle start launches a read request
  a_r2_start_reads: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && !done |=> req_valid && !req_write);
endmodule

// File: tb/flash_toggle_poller_test.sv
`timescale 1ns/100ps
module flash_toggle_poller_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       busy, done, error;
  logic       req_valid, req_write, rsp_ready;
  logic       req_ready = 1'b0;
  logic [7:0] req_data;
  logic       rsp_valid = 1'b0;
  logic [7:0] rsp_data = 8'h00;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  flash_toggle_poller uut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .error(error), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_data(req_data), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // toggle bit value seen by read i when it flips for the first k reads
  function automatic bit tbit(input int i, input int k);
    int m;
    m = (i < k) ? i : k;
    return m[0];
  endfunction

  // expected read count, outcome and whether a re-check decided
  function automatic void predict(input int k, input int d5, output int nrd,
                                  output bit fl, output bit rchk);
    int j;
    fl = 1'b0; rchk = 1'b0; nrd = 2;
    for (j = 1; j < 200; j++) begin
      if (tbit(j, k) == tbit(j-1, k)) begin nrd = j + 1; return; end
      if (j >= d5) begin
        rchk = 1'b1;
        nrd  = j + 2;
        fl   = (tbit(j+1, k) != tbit(j, k));
        return;
      end
    end
  endfunction

  function automatic logic [7:0] status(input int i, input int k, input int d5);
    logic [7:0] v;
    v = 8'($urandom);
    v[6] = tbit(i, k);
    v[5] = (i >= d5);
    return v;
  endfunction

  task automatic run_case(input int k, input int d5, input bit restart);
    int  exp_rd, nrd, nwr, cyc, stall, dly;
    bit  exp_fail, rchk, fin, got_err, inreq, pend, hold_bad;
    logic [7:0] wdata;
    string tag;
    nrd = 0; nwr = 0; cyc = 0; stall = 0; dly = 0; wdata = 8'h00;
    fin = 0; got_err = 0; inreq = 0; pend = 0; hold_bad = 0;
    predict(k, d5, exp_rd, exp_fail, rchk);
    tag = exp_fail ? "R8" : (rchk ? "R7" : (exp_rd > 2 ? "R6" : "R5"));

    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy == 1'b1, "R9 busy after start", int'(busy), 1);
    check(rsp_ready == 1'b0, "R4 no rsp_ready while requesting", int'(rsp_ready), 0);

    while (!fin && cyc < 3000) begin
      @(negedge clk); cyc++;
      if (restart) begin
        if (cyc == 3) start = 1'b1;
        else if (cyc == 4) start = 1'b0;
      end
      rsp_valid = 1'b0;
      req_ready = 1'b0;
      if (done) begin
        got_err = error;
        fin = 1;
      end else if (pend) begin
        if (dly == 0) begin
          rsp_valid = 1'b1;
          rsp_data  = status(nrd, k, d5);
          nrd++;
          pend = 0;
        end else dly--;
      end else if (inreq) begin
        if (!req_valid) hold_bad = 1;
        else if (stall == 0) begin
          req_ready = 1'b1;
          inreq = 0;
          if (req_write) begin nwr++; wdata = req_data; end
          else begin pend = 1; dly = $urandom % 3; end
        end else stall--;
      end else if (req_valid) begin
        inreq = 1;
        stall = $urandom % 3;
      end
    end
    rsp_valid = 1'b0;
    req_ready = 1'b0;

    check(fin, "R9 watchdog: done never seen", int'(fin), 1);
    check(nrd == exp_rd, {tag, " read count"}, nrd, exp_rd);
    if (restart) check(nrd == exp_rd, "R2 restart ignored while busy", nrd, exp_rd);
    check(got_err == exp_fail, "R10 outcome with noisy status bits", int'(got_err), int'(exp_fail));
    check(nwr == (exp_fail ? 1 : 0), "R8 reset write count", nwr, exp_fail ? 1 : 0);
    if (exp_fail) check(wdata == 8'hF0, "R8 reset write data", int'(wdata), 'hF0);
    check(!hold_bad, "R3 request held until ready", int'(hold_bad), 0);
    @(negedge clk);
    check(!done && !busy && !req_valid && !rsp_ready, "R9 single done pulse, idle after",
          int'({done, busy, req_valid, rsp_ready}), 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(!busy && !done && !error && !req_valid && !rsp_ready, "R1 reset state",
          int'({busy, done, error, req_valid, rsp_ready}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !req_valid, "R1 idle after reset release",
          int'({busy, req_valid}), 0);

    run_case(0, 99, 0);   // immediate success
    run_case(1, 99, 0);   // one flip then steady
    run_case(5, 99, 1);   // long polling, restart mid-run
    run_case(40, 2, 0);   // timeout while toggling: failure
    run_case(3, 3, 0);    // toggle stops together with timeout: success
    run_case(4, 3, 0);    // re-check still toggling: failure
    run_case(2, 0, 0);    // timeout high from first read
    for (int n = 0; n < 25; n++)
      run_case(int'($urandom % 13), int'($urandom % 15), bit'($urandom % 2));

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule